// File: doc/BRIEF.md
# Inter-processor command dispatcher

This block turns one write to a command register into an action on one processor. Software writes a 64-bit command word. The word holds a command type, a target processor number and a vector. The block checks the command and, one clock later, drives exactly one of four outputs for the chosen processor:

- an interrupt post, which carries the vector;
- a reset request;
- a halt request;
- a resume request.

A command aimed at a processor number that is not present is dropped and leaves no trace. A reset command counts only when its vector equals a configured power-on trap code. Any other reset command is dropped and raises an error strobe instead.

The block also keeps a halted flag for every processor. A halt command sets the flag. A valid reset or a resume clears it. The surrounding logic reads these flags, for example to keep interrupts away from a stopped core.

Top module: `ipi_dispatch`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, every action output, `cmd_error` and every bit of `halted` are zero.
- R2: The command fields sit at fixed bit positions: type in bits 17:16, target in bits 12:8 and vector in bits 5:0. Every other bit of `wr_data` has no effect.
- R3: Type 0 (post) to a present target makes `post_valid` high for one cycle, one cycle after the write. In that cycle `post_cpu` equals the target and `post_vec` equals the vector. Both fields are zero whenever `post_valid` is low.
- R4: Type 1 (reset) whose vector equals `POR_VEC` (default 6'h01) to a present target pulses bit *target* of `reset_req` for one cycle and clears `halted[target]`.
- R5: Type 1 whose vector differs from `POR_VEC`, to a present target, drives no action output, leaves `halted` unchanged and pulses `cmd_error` for one cycle.
- R6: Type 2 (halt) to a present target pulses bit *target* of `halt_req` and sets `halted[target]`.
- R7: Type 3 (resume) to a present target pulses bit *target* of `resume_req` and clears `halted[target]`.
- R8: A target at or above `cpu_count` (or at or above `MAX_CPUS`) drives no output, raises no error and leaves `halted` unchanged.
- R9: Every action output and `cmd_error` is a single-cycle pulse. At most one of them is active in any cycle, and none is active in a cycle that follows a cycle without a write.
- R10: A `halted` bit keeps its value until a command of type 1, 2 or 3 reaches that same processor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Command register write strobe |
| wr_data | input | 64 | Command word |
| cpu_count | input | $clog2(MAX_CPUS+1) | Number of processors present |
| post_valid | output | 1 | Interrupt post pulse |
| post_cpu | output | 5 | Processor that receives the interrupt |
| post_vec | output | 6 | Interrupt vector |
| reset_req | output | MAX_CPUS | One-hot reset request pulse |
| halt_req | output | MAX_CPUS | One-hot halt request pulse |
| resume_req | output | MAX_CPUS | One-hot resume request pulse |
| cmd_error | output | 1 | Pulse for a reset command with a wrong vector |
| halted | output | MAX_CPUS | Halted flag per processor |

## Verification
A write sampled at clock edge k shows up at the outputs right after edge k:

- the action pulse or `cmd_error`;
- the updated `halted` bit.

The bench drives every write on a falling edge. It then compares every output against its model on the next falling edge, which is exactly one register stage later. On the falling edge after that, it checks that every pulse has dropped back to zero while `halted` holds its value. The model sees only the command word and `cpu_count`, so each check falls at a fixed offset from its stimulus and never waits on the design.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  localparam int TYPE_LSB = 16;
  localparam int TGT_LSB  = 8;
  localparam int VEC_LSB  = 0;
  localparam int TYPE_W   = 2;
  localparam int TGT_W    = 5;
  localparam int VEC_W    = 6;

  typedef enum logic [TYPE_W-1:0] {
    CMD_POST   = 2'd0,
    CMD_RESET  = 2'd1,
    CMD_HALT   = 2'd2,
    CMD_RESUME = 2'd3
  } ipi_cmd_e;

  // One decoded command. At most one of the action flags is set.
  typedef struct packed {
    logic             post;
    logic             rst;
    logic             halt;
    logic             resume;
    logic             err;
    logic [TGT_W-1:0] tgt;
    logic [VEC_W-1:0] vec;
  } ipi_dec_t;

endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
  import ipi_pkg::*;
#(
  parameter int               MAX_CPUS = 32,
  parameter int               CNT_W    = $clog2(MAX_CPUS + 1),
  parameter logic [VEC_W-1:0] POR_VEC  = 6'h01
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [63:0]      wr_data,
  input  logic [CNT_W-1:0] cpu_count,
  output ipi_dec_t         dec
);

  localparam int CMP_W = ((CNT_W > TGT_W) ? CNT_W : TGT_W) + 1;

  ipi_cmd_e         kind;
  logic [TGT_W-1:0] tgt;
  logic [VEC_W-1:0] vec;
  logic [CMP_W-1:0] tgt_x;
  logic [CMP_W-1:0] cnt_x;
  logic [CMP_W-1:0] max_x;
  logic             present;
  logic             por_ok;
  logic             unused_bits;

  assign kind  = ipi_cmd_e'(wr_data[TYPE_LSB +: TYPE_W]);
  assign tgt   = wr_data[TGT_LSB +: TGT_W];
  assign vec   = wr_data[VEC_LSB +: VEC_W];

  // Bits outside the three fields are ignored.
  assign unused_bits = ^{wr_data[63:18], wr_data[15:13], wr_data[7:6]};

  assign tgt_x   = CMP_W'(tgt);
  assign cnt_x   = CMP_W'(cpu_count);
  assign max_x   = CMP_W'(MAX_CPUS);
  assign present = (tgt_x < cnt_x) && (tgt_x < max_x);
  assign por_ok  = (vec == POR_VEC);

  always_comb begin
    dec     = '0;
    dec.tgt = tgt;
    dec.vec = vec;
    if (wr_en && present) begin
      unique case (kind)
        CMD_POST:   dec.post   = 1'b1;
        CMD_RESET: begin
          dec.rst = por_ok;
          dec.err = !por_ok;
        end
        CMD_HALT:   dec.halt   = 1'b1;
        CMD_RESUME: dec.resume = 1'b1;
        default:    dec        = '0;
      endcase
    end
  end

  AST_DEC_RANGE: assert property (@(posedge clk) disable iff (rst)
    (dec.post || dec.rst || dec.halt || dec.resume || dec.err) |-> (CMP_W'(dec.tgt) < CMP_W'(cpu_count))); // R8
  AST_DEC_POR: assert property (@(posedge clk) disable iff (rst)
    dec.rst |-> (wr_data[VEC_LSB +: VEC_W] == POR_VEC)); // R4
  AST_DEC_ERR: assert property (@(posedge clk) disable iff (rst)
    dec.err |-> (wr_data[TYPE_LSB +: TYPE_W] == 2'd1)); // R5
  AST_DEC_SINGLE: assert property (@(posedge clk) disable iff (rst)
    $countones({dec.post, dec.rst, dec.halt, dec.resume, dec.err}) <= 1); // R9

endmodule

// File: rtl/ipi_pulse_gen.sv
module ipi_pulse_gen
  import ipi_pkg::*;
#(
  parameter int MAX_CPUS = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  ipi_dec_t            dec,
  output logic                post_valid,
  output logic [TGT_W-1:0]    post_cpu,
  output logic [VEC_W-1:0]    post_vec,
  output logic [MAX_CPUS-1:0] reset_req,
  output logic [MAX_CPUS-1:0] halt_req,
  output logic [MAX_CPUS-1:0] resume_req,
  output logic                cmd_error
);

  logic [MAX_CPUS-1:0] sel;

  for (genvar g = 0; g < MAX_CPUS; g++) begin : g_sel
    assign sel[g] = (32'(dec.tgt) == g);

    always_ff @(posedge clk) begin
      if (rst) begin
        reset_req[g]  <= 1'b0;
        halt_req[g]   <= 1'b0;
        resume_req[g] <= 1'b0;
      end else begin
        reset_req[g]  <= dec.rst    && sel[g];
        halt_req[g]   <= dec.halt   && sel[g];
        resume_req[g] <= dec.resume && sel[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      post_valid <= 1'b0;
      post_cpu   <= '0;
      post_vec   <= '0;
      cmd_error  <= 1'b0;
    end else begin
      post_valid <= dec.post;
      post_cpu   <= dec.post ? dec.tgt : '0;
      post_vec   <= dec.post ? dec.vec : '0;
      cmd_error  <= dec.err;
    end
  end

  AST_ONEHOT_RESET: assert property (@(posedge clk) disable iff (rst)
    $onehot0(reset_req)); // R4
  AST_ONEHOT_HALT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(halt_req)); // R6
  AST_ONEHOT_RESUME: assert property (@(posedge clk) disable iff (rst)
    $onehot0(resume_req)); // R7
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
    $countones({post_valid, |reset_req, |halt_req, |resume_req, cmd_error}) <= 1); // R9
  AST_QUIET_AFTER_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(dec.post || dec.rst || dec.halt || dec.resume || dec.err)
      |=> !post_valid && !cmd_error && (reset_req == '0) && (halt_req == '0) && (resume_req == '0)); // R9
  AST_POST_FIELDS: assert property (@(posedge clk) disable iff (rst)
    !post_valid |-> (post_cpu == '0) && (post_vec == '0)); // R3

endmodule

// File: rtl/ipi_halt_track.sv
module ipi_halt_track
  import ipi_pkg::*;
#(
  parameter int MAX_CPUS = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  ipi_dec_t            dec,
  output logic [MAX_CPUS-1:0] halted
);

  for (genvar g = 0; g < MAX_CPUS; g++) begin : g_flag
    logic hit;
    assign hit = (32'(dec.tgt) == g);

    always_ff @(posedge clk) begin
      if (rst) begin
        halted[g] <= 1'b0;
      end else if (hit && dec.halt) begin
        halted[g] <= 1'b1;
      end else if (hit && (dec.rst || dec.resume)) begin
        halted[g] <= 1'b0;
      end
    end
  end

  AST_HALT_SETS: assert property (@(posedge clk) disable iff (rst)
    dec.halt |=> halted[$past(dec.tgt)]); // R6
  AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (dec.rst || dec.resume) |=> !halted[$past(dec.tgt)]); // R7
  AST_HALT_KEEP: assert property (@(posedge clk) disable iff (rst)
    !(dec.rst || dec.halt || dec.resume) |=> $stable(halted)); // R10

endmodule

// File: rtl/ipi_dispatch.sv
module ipi_dispatch
  import ipi_pkg::*;
#(
  parameter int               MAX_CPUS = 32,
  parameter int               CNT_W    = $clog2(MAX_CPUS + 1),
  parameter logic [VEC_W-1:0] POR_VEC  = 6'h01
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [63:0]         wr_data,
  input  logic [CNT_W-1:0]    cpu_count,
  output logic                post_valid,
  output logic [TGT_W-1:0]    post_cpu,
  output logic [VEC_W-1:0]    post_vec,
  output logic [MAX_CPUS-1:0] reset_req,
  output logic [MAX_CPUS-1:0] halt_req,
  output logic [MAX_CPUS-1:0] resume_req,
  output logic                cmd_error,
  output logic [MAX_CPUS-1:0] halted
);

  ipi_dec_t dec;

  ipi_decode #(
    .MAX_CPUS (MAX_CPUS),
    .CNT_W    (CNT_W),
    .POR_VEC  (POR_VEC)
  ) u_decode (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .cpu_count (cpu_count),
    .dec       (dec)
  );

  ipi_pulse_gen #(
    .MAX_CPUS (MAX_CPUS)
  ) u_pulse (
    .clk        (clk),
    .rst        (rst),
    .dec        (dec),
    .post_valid (post_valid),
    .post_cpu   (post_cpu),
    .post_vec   (post_vec),
    .reset_req  (reset_req),
    .halt_req   (halt_req),
    .resume_req (resume_req),
    .cmd_error  (cmd_error)
  );

  ipi_halt_track #(
    .MAX_CPUS (MAX_CPUS)
  ) u_halt (
    .clk    (clk),
    .rst    (rst),
    .dec    (dec),
    .halted (halted)
  );

  AST_RESET_NEEDS_POR: assert property (@(posedge clk) disable iff (rst)
    (|reset_req) |-> ($past(wr_data[VEC_LSB +: VEC_W]) == POR_VEC)); // R4
  AST_POST_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    post_valid |-> (32'(post_cpu) < 32'($past(cpu_count)))); // R8
  AST_NO_WRITE_NO_ACTION: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> !post_valid && !cmd_error && (reset_req == '0) && (halt_req == '0) && (resume_req == '0)); // R9

endmodule

// File: tb/test_ipi_dispatch.sv
module test_ipi_dispatch;

  localparam int          NCPU = 8;
  localparam int          CW   = $clog2(NCPU + 1);
  localparam logic [5:0]  POR  = 6'h01;
  localparam int          OW   = 1 + 5 + 6 + 4 * NCPU + 1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            wr_en = 1'b0;
  logic [63:0]     wr_data = '0;
  logic [CW-1:0]   cpu_count = CW'(NCPU);
  logic            post_valid;
  logic [4:0]      post_cpu;
  logic [5:0]      post_vec;
  logic [NCPU-1:0] reset_req, halt_req, resume_req, halted;
  logic            cmd_error;

  int checks = 0;
  int errors = 0;
  logic [NCPU-1:0] m_halted = '0;

  always #5 clk = ~clk;

  ipi_dispatch #(.MAX_CPUS(NCPU), .POR_VEC(POR)) i_ipi_dispatch (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .cpu_count(cpu_count),
    .post_valid(post_valid), .post_cpu(post_cpu), .post_vec(post_vec),
    .reset_req(reset_req), .halt_req(halt_req), .resume_req(resume_req),
    .cmd_error(cmd_error), .halted(halted)
  );

  function automatic logic [OW-1:0] observed();
    return {post_valid, post_cpu, post_vec, reset_req, halt_req, resume_req, cmd_error, halted};
  endfunction

  task automatic check(input string tag, input logic [OW-1:0] exp);
    logic [OW-1:0] act;
    act = observed();
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One command: drive, check the result one edge later, check the pulse ends.
  task automatic send(input int ty, input int tgt, input int vec, input int cnt, input bit junk);
    logic [OW-1:0] exp;
    logic [NCPU-1:0] onehot;
    logic ev, er;
    logic [4:0] ec;
    logic [5:0] evv;
    logic [NCPU-1:0] er_m, eh_m, es_m;
    bit present;
    string tag;
    present = (tgt < cnt);
    onehot = present ? (NCPU'(1) << tgt) : '0;
    ev = 0; ec = 0; evv = 0; er = 0; er_m = 0; eh_m = 0; es_m = 0;
    tag = "R8";
    if (present) begin
      case (ty)
        0: begin ev = 1; ec = 5'(tgt); evv = 6'(vec); tag = junk ? "R2/R3" : "R3"; end
        1: if (6'(vec) == POR) begin
             er_m = onehot; m_halted &= ~onehot; tag = "R4";
           end else begin
             er = 1; tag = "R5";
           end
        2: begin eh_m = onehot; m_halted |= onehot; tag = "R6"; end
        default: begin es_m = onehot; m_halted &= ~onehot; tag = "R7"; end
      endcase
    end
    @(negedge clk);
    cpu_count = CW'(cnt);
    wr_data = {junk ? 46'h2AAA_5555_1234 : 46'h0, 2'(ty), junk ? 3'b101 : 3'b000,
               5'(tgt), junk ? 2'b11 : 2'b00, 6'(vec)};
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
    exp = {ev, ec, evv, er_m, eh_m, es_m, er, m_halted};
    check(tag, exp);
    @(negedge clk);
    exp = {1'b0, 5'd0, 6'd0, {NCPU{1'b0}}, {NCPU{1'b0}}, {NCPU{1'b0}}, 1'b0, m_halted};
    check("R9/R10", exp);
  endtask

  initial begin
    int cyc;
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int counts[3];
    int vecs[4];
    counts = '{NCPU, 3, 0};
    vecs = '{0, 1, 2, 63};
    // R1: reset state, with a write applied during reset
    rst = 1'b1;
    wr_en = 1'b1;
    wr_data = 64'h0000_0000_0002_0300;
    repeat (3) @(negedge clk);
    check("R1", '0);
    wr_en = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check("R1", '0);
    for (int p = 0; p < 2; p++) begin
      for (int c = 0; c < 3; c++) begin
        for (int t = 0; t < 32; t++) begin
          for (int ty = 0; ty < 4; ty++) begin
            for (int v = 0; v < 4; v++) begin
              send(ty, t, vecs[v], counts[c], p[0]);
            end
          end
        end
      end
    end
    // R10: halt several processors, then act on others and confirm flags hold
    send(2, 1, 0, NCPU, 0);
    send(2, 6, 0, NCPU, 0);
    send(0, 1, 9, NCPU, 0);
    send(1, 1, 5, NCPU, 0);
    send(3, 2, 0, NCPU, 0);
    send(2, 7, 0, 4, 0);
    send(1, 6, 1, NCPU, 0);
    send(3, 1, 0, NCPU, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule